// File: doc/BRIEF.md
# Relocating Program Image Loader

The block copies a small program image from a word stream into memory so that the image starts at a word base chosen by the caller. The loaded image is absolute code for that base. On the way through it reads the opcode of each code word and adds the base to the one operand byte that holds a memory offset or a jump target. Register codes, constants and all other bytes are written unchanged.

A caller sets the base and pulses `start`. It then streams the image with a valid/ready handshake and ends the image with an all-ones word. Data comes first: the first eight words of every image are data and are never changed. The block writes one memory word for each accepted image word, at the base plus the word's position. It pulses `done` when the terminator arrives. Loading stops and `error` stays raised if a patched operand no longer fits in a byte, or if the image grows beyond its size limit.

Top module: `reloc_loader`

## Requirements
- R1: After reset, `in_ready`, `mem_we`, `done` and `error` are all low.
- R2: `in_ready` is high only between an accepted `start` and the end of the load. The image word at position N (N counted from 0) is written to address `base + N` one cycle after it is accepted, with exactly one write per accepted non-terminator word. Cycles with `in_valid` low write nothing.
- R3: Image words at positions 0 to 7 are written unchanged, whatever their contents.
- R4: In a code word, bits 31:24 are the opcode, bits 23:16 are operand A and bits 15:8 are operand B. The base is added to operand A for opcodes 0x82, 0x84, 0x87, 0x89, 0x8C, 0x8E and 0x90 to 0x94. The base is added to operand B for opcodes 0x83, 0x88 and 0x8D. Every other byte, and every byte of a word with any other opcode, is written unchanged.
- R5: The word 0xFFFFFFFF ends the load and is not written. `done` is high for exactly the one cycle that follows the cycle in which the terminator is accepted, and `in_ready` then falls.
- R6: A patched operand sum above 255 sets `error`. That word is not written, `in_ready` falls, no later write occurs, `done` does not pulse, and `error` stays high until the next `start`.
- R7: An image may hold at most 31 words. A 32nd non-terminator word sets `error` under the same rules as R6, and it is not written.
- R8: `start` is ignored while a load is in progress. The base captured at the accepted `start` is used for the whole load.
- R9: An image that is only the terminator causes no writes and still pulses `done`.
- R10: A patched operand sum of exactly 255 is legal and is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when the block is idle |
| base | input | ADDR_W | Word base address, captured at start |
| in_valid | input | 1 | Image word present on in_data |
| in_data | input | 32 | Image word |
| in_ready | output | 1 | Block accepts an image word this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write word address |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | One-cycle pulse after a clean load |
| error | output | 1 | Sticky load failure flag, cleared by start |

## Verification
Every one of the 256 opcode values passes through the code area of a series of loads, each load with its own base. An arithmetic model in the bench predicts each stored word, so a wrong operand choice for any single opcode is caught. The data area is filled with words that would be patched if they were code, which separates position-based classification from opcode-based classification. A known small program is loaded at base 32 with fixed expected bytes. Operand sums of 255 and 256, images of 31 and 32 words, an image with no content, input gaps, and a stray `start` in mid-load check the limits, the stop behaviour and the handshake.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    localparam int WORD_W = 32;
    localparam int OPND_W = 8;

    localparam logic [OPND_W-1:0] ALU_FIRST = 8'h81;
    localparam logic [OPND_W-1:0] ALU_LAST  = 8'h8F;
    localparam logic [OPND_W-1:0] JMP_FIRST = 8'h90;
    localparam logic [OPND_W-1:0] JMP_LAST  = 8'h94;
    localparam int ALU_FORMS = 5;
    localparam logic [WORD_W-1:0] END_WORD = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [OPND_W-1:0] opcode;
        logic [OPND_W-1:0] opa;
        logic [OPND_W-1:0] opb;
        logic [OPND_W-1:0] spare;
    } img_word_t;

    typedef enum logic [1:0] {
        FIX_NONE,
        FIX_OPA,
        FIX_OPB
    } fix_sel_e;

    typedef enum logic {
        LD_IDLE,
        LD_RUN
    } ld_state_e;

    // Arithmetic opcodes repeat in groups of five forms:
    // reg<-reg, mem<-reg, reg<-mem, mem<-const, reg<-const.
    function automatic fix_sel_e classify(input logic [OPND_W-1:0] opc);
        int unsigned form;
        fix_sel_e sel;
        sel = FIX_NONE;
        form = 0;
        if (opc >= ALU_FIRST && opc <= ALU_LAST) begin
            form = (int'(opc) - int'(ALU_FIRST)) % ALU_FORMS;
            case (form)
                1, 3:    sel = FIX_OPA;
                2:       sel = FIX_OPB;
                default: sel = FIX_NONE;
            endcase
        end else if (opc >= JMP_FIRST && opc <= JMP_LAST) begin
            sel = FIX_OPA;
        end
        return sel;
    endfunction

endpackage

// File: rtl/reloc_decode.sv
module reloc_decode
    import reloc_pkg::*;
(
    input  logic [OPND_W-1:0] opcode,
    input  logic              is_code,
    output fix_sel_e          sel
);
    always_comb begin
        sel = is_code ? classify(opcode) : FIX_NONE;
    end
endmodule

// File: rtl/reloc_patcher.sv
module reloc_patcher
    import reloc_pkg::*;
(
    input  img_word_t         word_in,
    input  fix_sel_e          sel,
    input  logic [OPND_W-1:0] base,
    output img_word_t         word_out,
    output logic              overflow
);
    logic [OPND_W-1:0] pick;
    logic [OPND_W:0]   sum;

    always_comb begin
        pick     = (sel == FIX_OPB) ? word_in.opb : word_in.opa;
        sum      = {1'b0, pick} + {1'b0, base};
        word_out = word_in;
        overflow = 1'b0;
        case (sel)
            FIX_OPA: begin
                word_out.opa = sum[OPND_W-1:0];
                overflow     = sum[OPND_W];
            end
            FIX_OPB: begin
                word_out.opb = sum[OPND_W-1:0];
                overflow     = sum[OPND_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/reloc_loader.sv
module reloc_loader
    import reloc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int MAX_WORDS  = 31,
    parameter int DATA_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic              error
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(MAX_WORDS);
    localparam logic [CNT_W-1:0] CODE_FROM = CNT_W'(DATA_WORDS);

    ld_state_e         state;
    logic [CNT_W-1:0]  pos;
    logic [ADDR_W-1:0] base_q;
    img_word_t         cur;
    img_word_t         fixed;
    fix_sel_e          sel;
    logic              ovf;
    logic              accept;
    logic              is_end;

    assign cur      = img_word_t'(in_data);
    assign in_ready = (state == LD_RUN);
    assign accept   = in_valid && in_ready;
    assign is_end   = (in_data == END_WORD);

    reloc_decode u_decode (
        .opcode  (cur.opcode),
        .is_code (pos >= CODE_FROM),
        .sel     (sel)
    );

    reloc_patcher u_patch (
        .word_in  (cur),
        .sel      (sel),
        .base     (base_q[OPND_W-1:0]),
        .word_out (fixed),
        .overflow (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LD_IDLE;
            pos       <= '0;
            base_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            done   <= 1'b0;
            case (state)
                LD_IDLE: begin
                    if (start) begin
                        state  <= LD_RUN;
                        pos    <= '0;
                        base_q <= base;
                        error  <= 1'b0;
                    end
                end
                LD_RUN: begin
                    if (accept) begin
                        if (is_end) begin
                            state <= LD_IDLE;
                            done  <= 1'b1;
                        end else if (pos == LAST_POS || ovf) begin
                            state <= LD_IDLE;
                            error <= 1'b1;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_addr  <= base_q + ADDR_W'(pos);
                            mem_wdata <= fixed;
                            pos       <= pos + 1'b1;
                        end
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    // R2
    we_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(in_valid && in_ready));

    // R3
    data_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_end && pos < CODE_FROM) |=> (mem_we && mem_wdata == $past(in_data)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    no_write_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (!mem_we && !in_ready && !done));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LD_RUN && $past(state) == LD_RUN) |-> $stable(base_q));

endmodule

// File: tb/reloc_loader_test.sv
`timescale 1ns/1ps
module reloc_loader_test;
    localparam logic [31:0] TERM = 32'hFFFF_FFFF;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  base_in = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, mem_we, done, error;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int done_count = 0;
    logic [31:0] tb_mem [256];
    logic [31:0] img [64];

    always #2 clk = ~clk;

    reloc_loader uut (
        .clk(clk), .rst(rst), .start(start), .base(base_in),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .error(error)
    );

    always @(posedge clk) begin
        if (!rst && mem_we) begin
            tb_mem[mem_addr] = mem_wdata;
            wr_count = wr_count + 1;
        end
        if (!rst && done) done_count = done_count + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input int p, input int b);
        logic [7:0] opc, a, c;
        opc = w[31:24];
        a = w[23:16];
        c = w[15:8];
        if (p < 8) return w;
        if (opc inside {8'h82, 8'h84, 8'h87, 8'h89, 8'h8C, 8'h8E, [8'h90:8'h94]})
            a = 8'(int'(a) + b);
        else if (opc inside {8'h83, 8'h88, 8'h8D})
            c = 8'(int'(c) + b);
        return {opc, a, c, w[7:0]};
    endfunction

    task automatic start_load(input int b);
        for (int i = 0; i < 256; i++) tb_mem[i] = SENT;
        wr_count = 0;
        done_count = 0;
        @(negedge clk);
        start = 1'b1;
        base_in = 8'(b);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = w;
        @(posedge clk);
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Full clean load of img[0..n-1] plus terminator; checks done timing and contents.
    task automatic load_and_check(input int b, input int n, input bit gaps, input string req);
        start_load(b);
        chk(in_ready == 1'b1, "R2 ready after start", {31'b0, in_ready}, 32'd1);
        for (int i = 0; i < n; i++) begin
            push(img[i]);
            if (gaps && (i % 3 == 2)) gap();
        end
        push(TERM);
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b1, "R5 done pulse", {31'b0, done}, 32'd1);
        chk(error == 1'b0, "R6 no error on clean load", {31'b0, error}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", {31'b0, done}, 32'd0);
        chk(in_ready == 1'b0, "R5 ready drops", {31'b0, in_ready}, 32'd0);
        chk(wr_count == n, "R2 write count", 32'(wr_count), 32'(n));
        for (int i = 0; i < n; i++)
            chk(tb_mem[(b + i) % 256] === expect_word(img[i], i, b),
                (i < 8) ? "R3 data word" : req, tb_mem[(b + i) % 256], expect_word(img[i], i, b));
        if (b > 0) chk(tb_mem[b - 1] === SENT, "R2 below base", tb_mem[b - 1], SENT);
        if (b + n < 256) chk(tb_mem[b + n] === SENT, "R5 terminator not stored", tb_mem[b + n], SENT);
    endtask

    task automatic fill_data();
        for (int i = 0; i < 8; i++) img[i] = {8'h82 + 8'(i), 8'h10 + 8'(i), 8'h20, 8'h30};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(in_ready == 1'b0, "R1 ready", {31'b0, in_ready}, 32'd0);
        chk(mem_we == 1'b0, "R1 mem_we", {31'b0, mem_we}, 32'd0);
        chk(done == 1'b0, "R1 done", {31'b0, done}, 32'd0);
        chk(error == 1'b0, "R1 error", {31'b0, error}, 32'd0);

        // Small known program at base 32 (R4)
        for (int i = 0; i < 8; i++) img[i] = 32'h0;
        img[0] = 32'h0B00_0000;
        img[8]  = 32'h8504_0100;
        img[9]  = 32'h8701_0400;
        img[10] = 32'h8A04_0100;
        img[11] = 32'h8303_0000;
        img[12] = 32'h8B03_0400;
        img[13] = 32'h9109_0000;
        load_and_check(32, 14, 1'b0, "R4 known program");
        chk(tb_mem[41] === 32'h8721_0400, "R4 mem operand A", tb_mem[41], 32'h8721_0400);
        chk(tb_mem[43] === 32'h8303_2000, "R4 mem operand B", tb_mem[43], 32'h8303_2000);
        chk(tb_mem[45] === 32'h9129_0000, "R4 jump target", tb_mem[45], 32'h9129_0000);
        chk(tb_mem[40] === 32'h8504_0100, "R4 register and constant kept", tb_mem[40], 32'h8504_0100);

        // Opcode sweep over all 256 values, varying base and gaps (R4, R3, R2)
        for (int ch = 0; ch < 12; ch++) begin
            int nc;
            nc = (ch < 11) ? 23 : 3;
            fill_data();
            for (int k = 0; k < nc; k++) begin
                int op;
                op = ch * 23 + k;
                img[8 + k] = {8'(op), 8'((op * 7) & 63), 8'((op * 13) & 63), 8'(op) ^ 8'h5A};
            end
            load_and_check(5 + ch * 7, 8 + nc, ch[0], "R4 opcode sweep");
        end

        // Sum exactly 255 is legal (R10)
        fill_data();
        img[8] = 32'h9037_0000;
        img[9] = 32'h8301_3711;
        load_and_check(200, 10, 1'b0, "R10 sum 255");
        chk(tb_mem[208] === 32'h90FF_0000, "R10 operand A at 255", tb_mem[208], 32'h90FF_0000);
        chk(tb_mem[209] === 32'h8301_FF11, "R10 operand B at 255", tb_mem[209], 32'h8301_FF11);

        // Overflow stops the load (R6)
        start_load(200);
        fill_data();
        for (int i = 0; i < 8; i++) push(img[i]);
        push(32'h8105_0600);
        push(32'h8238_0400);
        push(32'h8501_0200);
        push(TERM);
        @(negedge clk);
        in_valid = 1'b0;
        chk(error == 1'b1, "R6 error set", {31'b0, error}, 32'd1);
        chk(in_ready == 1'b0, "R6 ready low", {31'b0, in_ready}, 32'd0);
        chk(wr_count == 9, "R6 writes stop", 32'(wr_count), 32'd9);
        chk(tb_mem[209] === SENT, "R6 bad word not stored", tb_mem[209], SENT);
        chk(done_count == 0, "R6 no done", 32'(done_count), 32'd0);
        repeat (5) @(negedge clk);
        chk(error == 1'b1, "R6 error held", {31'b0, error}, 32'd1);

        // 31 words is the limit (R7); a new start clears the error
        fill_data();
        for (int i = 8; i < 31; i++) img[i] = 32'h8102_0300 + 32'(i);
        load_and_check(0, 31, 1'b0, "R7 full image");
        chk(error == 1'b0, "R6 error cleared by start", {31'b0, error}, 32'd0);

        // 32nd word fails (R7)
        start_load(64);
        for (int i = 0; i < 31; i++) push(img[i]);
        push(32'h8100_0000);
        push(TERM);
        @(negedge clk);
        in_valid = 1'b0;
        chk(error == 1'b1, "R7 error on 32nd word", {31'b0, error}, 32'd1);
        chk(wr_count == 31, "R7 32nd not written", 32'(wr_count), 32'd31);
        chk(tb_mem[95] === SENT, "R7 address past limit untouched", tb_mem[95], SENT);
        chk(done_count == 0, "R7 no done", 32'(done_count), 32'd0);

        // Empty image (R9)
        load_and_check(10, 0, 1'b0, "R9 empty");
        chk(wr_count == 0, "R9 no writes", 32'(wr_count), 32'd0);

        // Stray start mid-load (R8)
        fill_data();
        img[8] = 32'h8703_0100;
        img[9] = 32'h9202_0000;
        start_load(40);
        for (int i = 0; i < 4; i++) push(img[i]);
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        base_in = 8'd150;
        @(negedge clk);
        start = 1'b0;
        for (int i = 4; i < 10; i++) push(img[i]);
        push(TERM);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(wr_count == 10, "R8 write count", 32'(wr_count), 32'd10);
        chk(tb_mem[48] === 32'h872B_0100, "R8 original base kept", tb_mem[48], 32'h872B_0100);
        chk(tb_mem[49] === 32'h922A_0000, "R8 jump at original base", tb_mem[49], 32'h922A_0000);
        chk(tb_mem[154] === SENT, "R8 new base unused", tb_mem[154], SENT);
        chk(done_count == 1, "R8 single done", 32'(done_count), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule